// File: doc/BRIEF.md
# PHY discovery and link resolver

This block is the management-side controller that brings up an Ethernet port after reset. It reads PHY registers through a simple request/done management access port. Bit-level serialisation of the management bus lies outside this block. It first searches the PHY address space for an attached device. It then waits for the link and, where enabled, for auto-negotiation to finish. Finally it works out the speed and duplex setting that the MAC must use.

Every management read has its own timeout. A read that times out behaves as if the PHY returned all ones. The whole link wait is bounded by a second, longer timeout. Both limits are counted in clock cycles and derived from a clock-frequency parameter: a read gets half a second and the link wait gets four seconds.

The sequence runs once on its own after reset. A start pulse while idle runs it again. A one-cycle done pulse marks the moment the result outputs become valid.

Top module: `phy_link_resolver`

## Requirements
- R1: Identifier register 2 is read at PHY addresses in ascending order from 0. A value other than 0x0000 and 0xFFFF stops the scan, and that address is reported with found_o=1.
- R2: If all 32 addresses (0..31) give 0x0000 or 0xFFFF, the result is found_o=0, link_up_o=0, speed100_o=1, full_duplex_o=1, after exactly 32 identifier reads and no other read.
- R3: After a PHY is found, the control register (0) is read once and the status register (1) is read repeatedly. Polling stops when status bit 2 (link) is set and either control bit 12 (auto-negotiation enable) is clear or status bit 5 (auto-negotiation complete) is set.
- R4: A status read that finishes at least LINK_CYC = 4*CLK_HZ cycles after polling began ends the polling. If its link bit is clear, the result is link_up_o=0, speed100_o=1, full_duplex_o=1.
- R5: Each access is a one-cycle mgmt_req_o strobe, with mgmt_phy_o and mgmt_reg_o held until completion. A mgmt_done_i pulse completes the access and delivers mgmt_rdata_i.
- R6: An access with no mgmt_done_i within ACC_CYC = CLK_HZ/2 cycles of its strobe completes as a read of 0xFFFF.
- R7: With auto-negotiation enabled and complete, registers 4 (advertisement) and 5 (partner ability) are read and ANDed. The first set bit picks the result in this order: bit 8 gives 100 full (1,1), bit 7 gives 100 half (1,0), bit 6 gives 10 full (0,1), bit 5 gives 10 half (0,0). With none set, the result is (1,1). Pairs are written as (speed100_o, full_duplex_o).
- R8: When the link is up and auto-negotiation is disabled or has not completed, speed100_o is control bit 13 and full_duplex_o is control bit 8.
- R9: In reset, found_o=0, link_up_o=0, phy_addr_o=0, speed100_o=1, full_duplex_o=1, done_o=0 and mgmt_req_o=0.
- R10: The sequence starts by itself after reset and again on start_i while idle. done_o is a one-cycle pulse, issued in the same cycle as the final result values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Re-run the sequence (taken while idle) |
| mgmt_req_o | output | 1 | One-cycle read request strobe |
| mgmt_phy_o | output | 5 | PHY address of the current access |
| mgmt_reg_o | output | 5 | Register number of the current access |
| mgmt_done_i | input | 1 | Read completion pulse |
| mgmt_rdata_i | input | 16 | Read data, valid with mgmt_done_i |
| found_o | output | 1 | A PHY with a valid identifier was found |
| phy_addr_o | output | 5 | Address of the found PHY |
| link_up_o | output | 1 | Link reported up |
| speed100_o | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_duplex_o | output | 1 | 1 = full duplex |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest paths to reach are the two timeouts, because a cooperative PHY model never triggers them. One is a management read that never completes. The other is a link that comes up while auto-negotiation never finishes.

The bench shortens both limits through CLK_HZ. Its PHY stub can be made silent for every read, or for every read except identifier reads, so that the all-ones substitution drives the control, status and ability decoding. The stub can also be told to report link down for a chosen number of status reads, or never to report auto-negotiation complete.

// File: rtl/phy_lr_pkg.sv
package phy_lr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CTRL,
        ST_POLL,
        ST_ADV,
        ST_LPA
    } lr_state_e;

    // Management register numbers
    localparam logic [4:0] MR_CTRL = 5'd0;
    localparam logic [4:0] MR_STAT = 5'd1;
    localparam logic [4:0] MR_ID1  = 5'd2;
    localparam logic [4:0] MR_ADV  = 5'd4;
    localparam logic [4:0] MR_LPA  = 5'd5;

    // Bit positions inside the registers
    localparam int B_LINK   = 2;
    localparam int B_ANDONE = 5;
    localparam int B_ANEN   = 12;
    localparam int B_SPD    = 13;
    localparam int B_FD     = 8;
    localparam int B_ABL_LO = 5;   // ability nibble is bits 8..5
    localparam int B_ABL_HI = 8;

    localparam logic [15:0] ID_EMPTY = 16'h0000;
    localparam logic [15:0] ID_FLOAT = 16'hFFFF;

endpackage

// File: rtl/mgmt_access_unit.sv
module mgmt_access_unit #(
    parameter int unsigned TIMEOUT_CYC = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic        done_i,
    input  logic [15:0] rdata_i,
    output logic        req_o,
    output logic        busy_o,
    output logic        fin_o,
    output logic [15:0] data_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic          req;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [15:0]   data;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d     = acc_q;
        acc_d.req = 1'b0;
        acc_d.fin = 1'b0;
        if (!acc_q.busy) begin
            if (go_i) begin
                acc_d.busy = 1'b1;
                acc_d.req  = 1'b1;
                acc_d.cnt  = '0;
            end
        end else if (done_i) begin
            acc_d.busy = 1'b0;
            acc_d.fin  = 1'b1;
            acc_d.data = rdata_i;
        end else if (acc_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
            acc_d.busy = 1'b0;
            acc_d.fin  = 1'b1;
            acc_d.data = 16'hFFFF;
        end else begin
            acc_d.cnt = acc_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign req_o  = acc_q.req;
    assign busy_o = acc_q.busy;
    assign fin_o  = acc_q.fin;
    assign data_o = acc_q.data;

    // R5: the request strobe lasts exactly one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R6: a completion not caused by done carries all ones
    a_r6_timeout_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && !$past(done_i)) |-> (data_o == 16'hFFFF));

    // R6: the wait counter never passes its limit
    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (acc_q.cnt < CW'(TIMEOUT_CYC)));

endmodule

// File: rtl/link_wait_timer.sv
module link_wait_timer #(
    parameter int unsigned LIMIT = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i)
            tmr_d.cnt = '0;
        else if (tmr_q.cnt != CW'(LIMIT))
            tmr_d.cnt = tmr_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = (tmr_q.cnt == CW'(LIMIT));

    // R4: once expired the timer stays expired until cleared
    a_r4_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i) |=> expired_o);

endmodule

// File: rtl/ability_resolver.sv
module ability_resolver (
    input  logic       use_an_i,
    input  logic [3:0] common_i,   // [3]=100 full [2]=100 half [1]=10 full [0]=10 half
    input  logic       ctrl_spd_i,
    input  logic       ctrl_fd_i,
    output logic       spd_o,
    output logic       fd_o
);
    always_comb begin
        if (!use_an_i) begin
            spd_o = ctrl_spd_i;
            fd_o  = ctrl_fd_i;
        end else if (common_i[3]) begin
            spd_o = 1'b1;
            fd_o  = 1'b1;
        end else if (common_i[2]) begin
            spd_o = 1'b1;
            fd_o  = 1'b0;
        end else if (common_i[1]) begin
            spd_o = 1'b0;
            fd_o  = 1'b1;
        end else if (common_i[0]) begin
            spd_o = 1'b0;
            fd_o  = 1'b0;
        end else begin
            spd_o = 1'b1;
            fd_o  = 1'b1;
        end
    end

    // R7: the strongest common ability always wins
    always_comb begin
        if (use_an_i && common_i[3])
            a_r7_top_priority: assert (spd_o && fd_o);
    end

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
    import phy_lr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        mgmt_req_o,
    output logic [4:0]  mgmt_phy_o,
    output logic [4:0]  mgmt_reg_o,
    input  logic        mgmt_done_i,
    input  logic [15:0] mgmt_rdata_i,
    output logic        found_o,
    output logic [4:0]  phy_addr_o,
    output logic        link_up_o,
    output logic        speed100_o,
    output logic        full_duplex_o,
    output logic        done_o
);
    localparam int unsigned ACC_CYC  = CLK_HZ / 2;
    localparam int unsigned LINK_CYC = CLK_HZ * 4;

    typedef struct packed {
        lr_state_e  state;
        logic       kick;
        logic       issue;
        logic       tclr;
        logic [4:0] phy;
        logic [4:0] rsel;
        logic       an_en;
        logic       c_spd;
        logic       c_fd;
        logic [3:0] adv;
        logic       found;
        logic [4:0] paddr;
        logic       link;
        logic       spd;
        logic       fd;
        logic       done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state: ST_IDLE, kick: 1'b1, issue: 1'b0, tclr: 1'b0,
        phy: 5'd0, rsel: MR_ID1, an_en: 1'b0, c_spd: 1'b0, c_fd: 1'b0,
        adv: 4'd0, found: 1'b0, paddr: 5'd0, link: 1'b0,
        spd: 1'b1, fd: 1'b1, done: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    logic        acc_busy;
    logic        acc_fin;
    logic [15:0] acc_data;
    logic        t_exp;
    logic        use_an;
    logic [3:0]  common;
    logic        res_spd;
    logic        res_fd;

    mgmt_access_unit #(.TIMEOUT_CYC(ACC_CYC)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (ctl_q.issue),
        .done_i  (mgmt_done_i),
        .rdata_i (mgmt_rdata_i),
        .req_o   (mgmt_req_o),
        .busy_o  (acc_busy),
        .fin_o   (acc_fin),
        .data_o  (acc_data)
    );

    link_wait_timer #(.LIMIT(LINK_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ctl_q.tclr),
        .expired_o (t_exp)
    );

    assign use_an = (ctl_q.state == ST_LPA);
    assign common = ctl_q.adv & acc_data[B_ABL_HI:B_ABL_LO];

    ability_resolver u_res (
        .use_an_i   (use_an),
        .common_i   (common),
        .ctrl_spd_i (ctl_q.c_spd),
        .ctrl_fd_i  (ctl_q.c_fd),
        .spd_o      (res_spd),
        .fd_o       (res_fd)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.issue = 1'b0;
        ctl_d.tclr  = 1'b0;
        ctl_d.done  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.kick || start_i) begin
                    ctl_d.kick  = 1'b0;
                    ctl_d.found = 1'b0;
                    ctl_d.link  = 1'b0;
                    ctl_d.spd   = 1'b1;
                    ctl_d.fd    = 1'b1;
                    ctl_d.paddr = 5'd0;
                    ctl_d.phy   = 5'd0;
                    ctl_d.rsel  = MR_ID1;
                    ctl_d.issue = 1'b1;
                    ctl_d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (acc_fin) begin
                    if (acc_data != ID_EMPTY && acc_data != ID_FLOAT) begin
                        ctl_d.found = 1'b1;
                        ctl_d.paddr = ctl_q.phy;
                        ctl_d.rsel  = MR_CTRL;
                        ctl_d.issue = 1'b1;
                        ctl_d.state = ST_CTRL;
                    end else if (&ctl_q.phy) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.phy   = ctl_q.phy + 5'd1;
                        ctl_d.issue = 1'b1;
                    end
                end
            end
            ST_CTRL: begin
                if (acc_fin) begin
                    ctl_d.an_en = acc_data[B_ANEN];
                    ctl_d.c_spd = acc_data[B_SPD];
                    ctl_d.c_fd  = acc_data[B_FD];
                    ctl_d.rsel  = MR_STAT;
                    ctl_d.issue = 1'b1;
                    ctl_d.tclr  = 1'b1;
                    ctl_d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                if (acc_fin) begin
                    if ((acc_data[B_LINK] && (!ctl_q.an_en || acc_data[B_ANDONE])) || t_exp) begin
                        ctl_d.link = acc_data[B_LINK];
                        if (!acc_data[B_LINK]) begin
                            ctl_d.done  = 1'b1;
                            ctl_d.state = ST_IDLE;
                        end else if (ctl_q.an_en && acc_data[B_ANDONE]) begin
                            ctl_d.rsel  = MR_ADV;
                            ctl_d.issue = 1'b1;
                            ctl_d.state = ST_ADV;
                        end else begin
                            ctl_d.spd   = res_spd;
                            ctl_d.fd    = res_fd;
                            ctl_d.done  = 1'b1;
                            ctl_d.state = ST_IDLE;
                        end
                    end else begin
                        ctl_d.issue = 1'b1;
                    end
                end
            end
            ST_ADV: begin
                if (acc_fin) begin
                    ctl_d.adv   = acc_data[B_ABL_HI:B_ABL_LO];
                    ctl_d.rsel  = MR_LPA;
                    ctl_d.issue = 1'b1;
                    ctl_d.state = ST_LPA;
                end
            end
            ST_LPA: begin
                if (acc_fin) begin
                    ctl_d.spd   = res_spd;
                    ctl_d.fd    = res_fd;
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign mgmt_phy_o    = ctl_q.phy;
    assign mgmt_reg_o    = ctl_q.rsel;
    assign found_o       = ctl_q.found;
    assign phy_addr_o    = ctl_q.paddr;
    assign link_up_o     = ctl_q.link;
    assign speed100_o    = ctl_q.spd;
    assign full_duplex_o = ctl_q.fd;
    assign done_o        = ctl_q.done;

    // R5: the access target does not move while an access is outstanding
    a_r5_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && $past(acc_busy)) |-> ($stable(mgmt_phy_o) && $stable(mgmt_reg_o)));

    // R5: a new access is only launched when none is outstanding
    a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.issue |-> !acc_busy);

    // R2: a not-found result carries the default configuration
    a_r2_notfound_default: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (!link_up_o && speed100_o && full_duplex_o));

    // R4: a link-down result carries the default configuration
    a_r4_linkdown_default: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !link_up_o) |-> (speed100_o && full_duplex_o));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/phy_link_resolver_tb.sv
`timescale 1ns/1ps
module phy_link_resolver_tb;
    localparam int unsigned CLK_HZ = 200;   // ACC_CYC = 100, LINK_CYC = 800

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mgmt_req_o;
    logic [4:0]  mgmt_phy_o;
    logic [4:0]  mgmt_reg_o;
    logic        mgmt_done_i = 1'b0;
    logic [15:0] mgmt_rdata_i = 16'h0;
    logic        found_o;
    logic [4:0]  phy_addr_o;
    logic        link_up_o;
    logic        speed100_o;
    logic        full_duplex_o;
    logic        done_o;

    always #10 clk = ~clk;   // 50 MHz

    phy_link_resolver #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mgmt_req_o(mgmt_req_o), .mgmt_phy_o(mgmt_phy_o), .mgmt_reg_o(mgmt_reg_o),
        .mgmt_done_i(mgmt_done_i), .mgmt_rdata_i(mgmt_rdata_i),
        .found_o(found_o), .phy_addr_o(phy_addr_o), .link_up_o(link_up_o),
        .speed100_o(speed100_o), .full_duplex_o(full_duplex_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // ---------------- PHY stub ----------------
    logic [15:0] id_tab [32];
    logic [15:0] ctrl_v, stat_v, adv_v, lpa_v;
    int link_after = 0;   // status reads reporting link down first
    int an_never   = 0;   // never report auto-negotiation complete
    int silent     = 0;   // 0 answer all, 1 answer none, 2 answer only identifier reads
    int id_reads   = 0;
    int st_reads   = 0;

    task automatic phys_clear();
        for (int i = 0; i < 32; i++) id_tab[i] = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
        ctrl_v = 16'h1000; stat_v = 16'h0024; adv_v = 16'h01E1; lpa_v = 16'h01E1;
        link_after = 0; an_never = 0; silent = 0;
        id_reads = 0; st_reads = 0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (mgmt_req_o) begin
                logic [4:0]  r_c;
                logic [4:0]  p_c;
                logic [15:0] val;
                r_c = mgmt_reg_o;
                p_c = mgmt_phy_o;
                case (r_c)
                    5'd2: begin val = id_tab[p_c]; id_reads++; end
                    5'd0: val = ctrl_v;
                    5'd1: begin
                        if (st_reads < link_after)  val = stat_v & ~16'h0024;
                        else if (an_never != 0)     val = stat_v & ~16'h0020;
                        else                        val = stat_v;
                        st_reads++;
                    end
                    5'd4: val = adv_v;
                    5'd5: val = lpa_v;
                    default: val = 16'h0000;
                endcase
                if (silent == 0 || (silent == 2 && r_c == 5'd2)) begin
                    repeat (2) @(negedge clk);
                    chk("R5 register held during access", int'(mgmt_reg_o), int'(r_c));
                    chk("R5 address held during access", int'(mgmt_phy_o), int'(p_c));
                    mgmt_done_i  = 1'b1;
                    mgmt_rdata_i = val;
                    @(negedge clk);
                    mgmt_done_i  = 1'b0;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic       found;
        logic [4:0] addr;
        logic       link;
        logic       spd;
        logic       fd;
        int         idr;   // expected identifier reads
        int         str;   // expected status reads, -1 = any
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected done pulse", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " found"}, int'(found_o), int'(e.found));
                    if (e.found) chk({t, " address"}, int'(phy_addr_o), int'(e.addr));
                    chk({t, " link"}, int'(link_up_o), int'(e.link));
                    chk({t, " speed100"}, int'(speed100_o), int'(e.spd));
                    chk({t, " duplex"}, int'(full_duplex_o), int'(e.fd));
                    chk({t, " id reads"}, id_reads, e.idr);
                    if (e.str >= 0) chk({t, " status reads"}, st_reads, e.str);
                end
            end
        end
    end

    task automatic run_case(input string tag, input exp_t e, input bit kick);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (kick) begin
            @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk({tag, " R10 done is one pulse"}, int'(done_o), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired, R10 sequence did not complete");
        finish_run();
    end

    initial begin
        exp_t e;
        // Case 1: auto run after reset. PHY at 5, link after 2 polls, common ability 100 half.
        phys_clear();
        id_tab[5] = 16'h0141;
        link_after = 2;
        lpa_v = 16'h00A1;
        repeat (3) @(negedge clk);
        chk("R9 reset found", int'(found_o), 0);
        chk("R9 reset link", int'(link_up_o), 0);
        chk("R9 reset address", int'(phy_addr_o), 0);
        chk("R9 reset speed100", int'(speed100_o), 1);
        chk("R9 reset duplex", int'(full_duplex_o), 1);
        chk("R9 reset done", int'(done_o), 0);
        chk("R9 reset request", int'(mgmt_req_o), 0);
        e = '{found:1, addr:5, link:1, spd:1, fd:0, idr:6, str:3};
        exp_q.push_back(e);
        tag_q.push_back("R10 auto run R1 R3 R7 100 half");
        rst_n = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        // Case 2: two PHYs, first one wins; common 10 full
        phys_clear();
        id_tab[7] = 16'h1234; id_tab[9] = 16'h5678;
        lpa_v = 16'h0061;
        e = '{found:1, addr:7, link:1, spd:0, fd:1, idr:8, str:1};
        run_case("R1 first of two, R7 10 full", e, 1'b1);

        // Case 3: PHY at the last address; common 10 half only
        phys_clear();
        id_tab[31] = 16'h2000;
        lpa_v = 16'h0021;
        e = '{found:1, addr:31, link:1, spd:0, fd:0, idr:32, str:1};
        run_case("R1 address 31, R7 10 half", e, 1'b1);

        // Case 4: no common ability, default stays
        phys_clear();
        id_tab[0] = 16'h0022;
        adv_v = 16'h0061; lpa_v = 16'h0181;
        e = '{found:1, addr:0, link:1, spd:1, fd:1, idr:1, str:1};
        run_case("R7 no common ability", e, 1'b1);

        // Case 5: 100 full beats 10 full
        phys_clear();
        id_tab[3] = 16'h0033;
        adv_v = 16'h0141; lpa_v = 16'h01E1;
        e = '{found:1, addr:3, link:1, spd:1, fd:1, idr:4, str:1};
        run_case("R7 100 full priority", e, 1'b1);

        // Case 6: auto-negotiation disabled, forced 10 full, link up at once
        phys_clear();
        id_tab[4] = 16'h0044;
        ctrl_v = 16'h0100; stat_v = 16'h0004;
        e = '{found:1, addr:4, link:1, spd:0, fd:1, idr:5, str:1};
        run_case("R8 forced 10 full", e, 1'b1);

        // Case 7: auto-negotiation disabled, link after 3 down polls, forced 100 half
        phys_clear();
        id_tab[6] = 16'h0066;
        ctrl_v = 16'h2000; stat_v = 16'h0004; link_after = 3;
        e = '{found:1, addr:6, link:1, spd:1, fd:0, idr:7, str:4};
        run_case("R3 polling continues, R8 forced 100 half", e, 1'b1);

        // Case 8: link never comes up
        phys_clear();
        id_tab[1] = 16'h0011;
        link_after = 100000;
        e = '{found:1, addr:1, link:0, spd:1, fd:1, idr:2, str:-1};
        run_case("R4 link wait timeout", e, 1'b1);

        // Case 9: link up but auto-negotiation never completes -> forced bits
        phys_clear();
        id_tab[2] = 16'h0202;
        ctrl_v = 16'h3000; an_never = 1;
        e = '{found:1, addr:2, link:1, spd:1, fd:0, idr:3, str:-1};
        run_case("R4 R8 negotiation incomplete", e, 1'b1);

        // Case 10: nothing attached
        phys_clear();
        e = '{found:0, addr:0, link:0, spd:1, fd:1, idr:32, str:0};
        run_case("R2 no PHY", e, 1'b1);

        // Case 11: management port never answers
        phys_clear();
        id_tab[8] = 16'h0808;
        silent = 1;
        e = '{found:0, addr:0, link:0, spd:1, fd:1, idr:32, str:0};
        run_case("R6 R2 silent port", e, 1'b1);

        // Case 12: identifier answered, all later reads time out as 0xFFFF
        phys_clear();
        id_tab[2] = 16'h0202;
        silent = 2;
        e = '{found:1, addr:2, link:1, spd:1, fd:1, idr:3, str:1};
        run_case("R6 timed-out reads give all ones", e, 1'b1);

        finish_run();
    end

endmodule